// File: doc/BRIEF.md
# Clock-Loss Resuscitation Watchdog

This block watches a system clock from a separate reference clock and reacts if the system clock stops. Each system-clock edge flips a toggle flop. The toggle is synchronised into the reference domain, and every change seen there reloads a down-counter with a programmed timeout. If detection is enabled and the counter runs out before the next change arrives, the block latches a fault. The fault drives a select-safe-source output, which the clock-switching logic outside the block uses to move the system onto a safe clock.

The fault flag is sticky. Software first repairs the cause, then pulses clear. A clear has no effect while the timeout condition or a force request is still present. A force input raises the fault on a healthy clock for test purposes. The block also builds an interrupt from three parts: the raw fault bit, an interrupt-enable bit and an interrupt-force bit.

The counter comes out of reset preset to all ones, which is 0xFF for the default 8-bit timeout. Whenever detection is off, the counter follows the timeout input.

Top module: `clk_resus_watch`

## Requirements
- R1: While rst_n is low and after its release with all inputs low, status_o, sel_safe_o, irq_raw_o and irq_o are all 0.
- R2: While det_en_i is 0, a stopped system clock never sets the fault, and the counter is reloaded from timeout_i on every reference edge.
- R3: With det_en_i at 1 and a running system clock whose edges arrive more often than timeout_i reference cycles, the fault never sets.
- R4: With the system clock stalled and the activity pipeline settled, the fault sets on the (T+1)-th reference edge after det_en_i is first sampled as 1, where T is timeout_i. T=0 sets it on the first edge. The counter steps down by one per edge while it waits.
- R5: Once set, the fault stays set until clear_i is sampled at 1 while neither expiry nor force is present. It then drops on that reference edge.
- R6: A clear_i sampled in a cycle where the timeout has expired with detection on, or where force_i is 1, is ignored and the fault stays set.
- R7: force_i sampled at 1 sets the fault on that reference edge, whether det_en_i is 0 or 1 and whether the system clock is running or not.
- R8: sel_safe_o, status_o and irq_raw_o rise together in the same reference cycle. irq_o is combinationally (irq_raw_o AND irq_en_i) OR irq_force_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock; all control logic runs on it |
| sys_clk | input | 1 | Monitored system clock |
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| det_en_i | input | 1 | Enables timeout detection |
| force_i | input | 1 | Forces a fault for test |
| clear_i | input | 1 | Clears the sticky fault once the cause is gone |
| timeout_i | input | TMO_W (8) | Timeout in reference cycles |
| irq_en_i | input | 1 | Interrupt enable |
| irq_force_i | input | 1 | Interrupt force |
| status_o | output | 1 | Sticky fault flag |
| sel_safe_o | output | 1 | Request to switch the system onto a safe clock source |
| irq_raw_o | output | 1 | Raw interrupt bit (fault present) |
| irq_o | output | 1 | Masked and forced interrupt |

## Verification
The in-RTL assertions cover several behaviours on every reference cycle:
- the one-per-edge countdown of the counter and its reload while detection is off;
- stickiness of the fault;
- the setting of the fault by expiry or by force, including when a clear arrives in the same cycle;
- the interrupt staying low when there is no raw fault and no force.

Some behaviours can only be shown by the bench scenarios. These are the exact (T+1)-edge latency from enable to fault, the absence of false faults on a running clock, the release of the fault by clear once the clock is back, and the T=0 boundary. All of them depend on how the stimulus on the system clock lines up with the synchroniser.

// File: rtl/crw_pkg.sv
package crw_pkg;

    // Counter action chosen each reference cycle
    typedef enum logic [1:0] {
        CNT_HOLD = 2'd0,
        CNT_LOAD = 2'd1,
        CNT_DEC  = 2'd2
    } cnt_op_e;

    // Sticky fault state
    typedef struct packed {
        logic flag;
    } fault_st_t;

endpackage

// File: rtl/crw_toggle.sv
module crw_toggle (
    input  logic sys_clk,
    input  logic rst_n,
    output logic tgl_o
);
    typedef struct packed {
        logic tgl;
    } tgl_st_t;

    tgl_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.tgl = ~st_q.tgl;
    end

    always_ff @(posedge sys_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tgl_o = st_q.tgl;
endmodule

// File: rtl/crw_sync.sv
module crw_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    typedef struct packed {
        logic [STAGES-1:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb begin
                st_d    = st_q;
                st_d.sh = d_i;
            end
        end else begin : g_chain
            always_comb begin
                st_d    = st_q;
                st_d.sh = {st_q.sh[STAGES-2:0], d_i};
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_o = st_q.sh[STAGES-1];
endmodule

// File: rtl/crw_timer.sv
module crw_timer
    import crw_pkg::*;
#(
    parameter int unsigned   TMO_W    = 8,
    parameter logic [TMO_W-1:0] TMO_INIT = {TMO_W{1'b1}}
) (
    input  logic             ref_clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tgl_sync_i,
    input  logic [TMO_W-1:0] tmo_i,
    output logic             expired_o
);
    localparam logic [TMO_W-1:0] ZERO = '0;
    localparam logic [TMO_W-1:0] ONE  = {{(TMO_W-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic [TMO_W-1:0] cnt;
        logic             last;
    } tmr_st_t;

    tmr_st_t st_d, st_q;
    cnt_op_e op;
    logic    act;

    always_comb begin
        act  = (tgl_sync_i != st_q.last);
        st_d = st_q;
        st_d.last = tgl_sync_i;
        if (!en_i || act)         op = CNT_LOAD;
        else if (st_q.cnt != ZERO) op = CNT_DEC;
        else                      op = CNT_HOLD;
        case (op)
            CNT_LOAD: st_d.cnt = tmo_i;
            CNT_DEC:  st_d.cnt = st_q.cnt - ONE;
            default:  st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt  <= TMO_INIT;
            st_q.last <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign expired_o = en_i && (st_q.cnt == ZERO);

    // R4
    count_down_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (en_i && !act && st_q.cnt != ZERO) |=> (st_q.cnt == $past(st_q.cnt) - ONE));

    // R2
    reload_off_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!en_i) |=> (st_q.cnt == $past(tmo_i)));
endmodule

// File: rtl/crw_fault.sv
module crw_fault
    import crw_pkg::*;
(
    input  logic ref_clk,
    input  logic rst_n,
    input  logic expired_i,
    input  logic force_i,
    input  logic clear_i,
    input  logic irq_en_i,
    input  logic irq_force_i,
    output logic status_o,
    output logic irq_raw_o,
    output logic irq_o
);
    fault_st_t st_d, st_q;
    logic      trigger;

    always_comb begin
        trigger = expired_i || force_i;
        st_d    = st_q;
        if (trigger)      st_d.flag = 1'b1;
        else if (clear_i) st_d.flag = 1'b0;
    end

    always_ff @(posedge ref_clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status_o  = st_q.flag;
    assign irq_raw_o = st_q.flag;
    assign irq_o     = (st_q.flag && irq_en_i) || irq_force_i;

    // R5
    sticky_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (st_q.flag && !clear_i) |=> st_q.flag);

    // R6
    clear_blocked_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (clear_i && (expired_i || force_i)) |=> st_q.flag);

    // R4
    expiry_sets_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        expired_i |=> st_q.flag);

    // R7
    force_sets_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        force_i |=> st_q.flag);

    // R8
    quiet_irq_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        (!irq_raw_o && !irq_force_i) |-> !irq_o);
endmodule

// File: rtl/clk_resus_watch.sv
module clk_resus_watch #(
    parameter int unsigned TMO_W       = 8,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic             ref_clk,
    input  logic             sys_clk,
    input  logic             rst_n,
    input  logic             det_en_i,
    input  logic             force_i,
    input  logic             clear_i,
    input  logic [TMO_W-1:0] timeout_i,
    input  logic             irq_en_i,
    input  logic             irq_force_i,
    output logic             status_o,
    output logic             sel_safe_o,
    output logic             irq_raw_o,
    output logic             irq_o
);
    localparam logic [TMO_W-1:0] TMO_PRESET = {TMO_W{1'b1}};

    logic tgl_sys;
    logic tgl_ref;
    logic expired;
    logic flag;

    crw_toggle u_toggle (
        .sys_clk (sys_clk),
        .rst_n   (rst_n),
        .tgl_o   (tgl_sys)
    );

    crw_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (ref_clk),
        .rst_n (rst_n),
        .d_i   (tgl_sys),
        .q_o   (tgl_ref)
    );

    crw_timer #(.TMO_W(TMO_W), .TMO_INIT(TMO_PRESET)) u_timer (
        .ref_clk    (ref_clk),
        .rst_n      (rst_n),
        .en_i       (det_en_i),
        .tgl_sync_i (tgl_ref),
        .tmo_i      (timeout_i),
        .expired_o  (expired)
    );

    crw_fault u_fault (
        .ref_clk     (ref_clk),
        .rst_n       (rst_n),
        .expired_i   (expired),
        .force_i     (force_i),
        .clear_i     (clear_i),
        .irq_en_i    (irq_en_i),
        .irq_force_i (irq_force_i),
        .status_o    (flag),
        .irq_raw_o   (irq_raw_o),
        .irq_o       (irq_o)
    );

    assign status_o   = flag;
    assign sel_safe_o = flag;

    // R8
    safe_follows_raw_chk: assert property (@(posedge ref_clk) disable iff (!rst_n)
        $rose(irq_raw_o) |-> $rose(sel_safe_o));
endmodule

// File: tb/clk_resus_watch_test.sv
module clk_resus_watch_test;
    logic       ref_clk = 1'b0;
    logic       sys_clk = 1'b0;
    logic       sys_run = 1'b1;
    logic       rst_n   = 1'b0;
    logic       det_en_i = 1'b0, force_i = 1'b0, clear_i = 1'b0;
    logic [7:0] timeout_i = 8'd20;
    logic       irq_en_i = 1'b0, irq_force_i = 1'b0;
    logic       status_o, sel_safe_o, irq_raw_o, irq_o;

    int compared = 0;
    int mismatched = 0;
    int cycles = 0;

    clk_resus_watch uut (
        .ref_clk(ref_clk), .sys_clk(sys_clk), .rst_n(rst_n),
        .det_en_i(det_en_i), .force_i(force_i), .clear_i(clear_i),
        .timeout_i(timeout_i), .irq_en_i(irq_en_i), .irq_force_i(irq_force_i),
        .status_o(status_o), .sel_safe_o(sel_safe_o),
        .irq_raw_o(irq_raw_o), .irq_o(irq_o)
    );

    always #2.5 ref_clk = ~ref_clk;

    // system clock: 30 ns period, stops low when sys_run drops
    always begin
        if (sys_run) begin
            #15 sys_clk = 1'b1;
            #15 sys_clk = 1'b0;
        end else begin
            #5;
        end
    end

    always @(posedge ref_clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            mismatched = mismatched + 1;
            $display("FAIL watchdog: actual=%0d cycles expected<=50000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    task automatic check(input string req, input logic act, input logic exp);
        compared = compared + 1;
        if (act !== exp) begin
            mismatched = mismatched + 1;
            $display("FAIL %s: actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic pulse_clear();
        clear_i = 1'b1;
        @(negedge ref_clk);
        clear_i = 1'b0;
    endtask

    task automatic t_reset();
        repeat (4) @(negedge ref_clk);
        check("R1 status in reset", status_o, 1'b0);
        check("R1 sel_safe in reset", sel_safe_o, 1'b0);
        rst_n = 1'b1;
        repeat (3) @(negedge ref_clk);
        check("R1 irq_raw after reset", irq_raw_o, 1'b0);
        check("R1 irq after reset", irq_o, 1'b0);
    endtask

    task automatic t_disabled();
        det_en_i = 1'b0;
        sys_run  = 1'b0;
        repeat (300) @(negedge ref_clk);
        check("R2 no fault while disabled", status_o, 1'b0);
        sys_run = 1'b1;
        repeat (20) @(negedge ref_clk);
    endtask

    task automatic t_healthy();
        timeout_i = 8'd20;
        det_en_i  = 1'b1;
        repeat (400) @(negedge ref_clk);
        check("R3 no fault on running clock", status_o, 1'b0);
        det_en_i = 1'b0;
    endtask

    task automatic t_expiry(input logic [7:0] t);
        det_en_i  = 1'b0;
        timeout_i = t;
        sys_run   = 1'b0;
        repeat (20) @(negedge ref_clk);
        det_en_i = 1'b1;
        if (t != 8'd0) begin
            repeat (int'(t)) @(negedge ref_clk);
            check("R4 fault not yet at T edges", status_o, 1'b0);
        end
        @(negedge ref_clk);
        check("R4 fault at T+1 edges", status_o, 1'b1);
        check("R8 sel_safe same cycle", sel_safe_o, 1'b1);
        check("R8 irq_raw same cycle", irq_raw_o, 1'b1);
    endtask

    task automatic t_clear_blocked();
        pulse_clear();
        check("R6 clear ignored while expired", status_o, 1'b1);
    endtask

    task automatic t_sticky_clear();
        sys_run = 1'b1;
        repeat (40) @(negedge ref_clk);
        check("R5 fault sticky after clock returns", status_o, 1'b1);
        pulse_clear();
        check("R5 clear releases fault", status_o, 1'b0);
        check("R5 sel_safe released", sel_safe_o, 1'b0);
    endtask

    task automatic t_force();
        det_en_i = 1'b0;
        repeat (5) @(negedge ref_clk);
        force_i = 1'b1;
        clear_i = 1'b1;
        @(negedge ref_clk);
        force_i = 1'b0;
        clear_i = 1'b0;
        check("R7 force sets fault with detection off", status_o, 1'b1);
        check("R6 clear ignored during force", status_o, 1'b1);
        pulse_clear();
        check("R5 clear after force", status_o, 1'b0);
    endtask

    task automatic t_irq();
        irq_force_i = 1'b1;
        #1;
        check("R8 irq force with no fault", irq_o, 1'b1);
        irq_force_i = 1'b0;
        irq_en_i    = 1'b1;
        #1;
        check("R8 irq enabled but no fault", irq_o, 1'b0);
        @(negedge ref_clk);
        force_i = 1'b1;
        @(negedge ref_clk);
        force_i  = 1'b0;
        irq_en_i = 1'b0;
        #1;
        check("R8 raw set", irq_raw_o, 1'b1);
        check("R8 irq masked", irq_o, 1'b0);
        irq_en_i = 1'b1;
        #1;
        check("R8 irq unmasked", irq_o, 1'b1);
        @(negedge ref_clk);
        pulse_clear();
        irq_en_i = 1'b0;
    endtask

    initial begin
        t_reset();
        t_disabled();
        t_healthy();
        t_expiry(8'd12);
        t_clear_blocked();
        t_sticky_clear();
        t_force();
        t_irq();
        t_expiry(8'd0);
        det_en_i = 1'b0;
        sys_run  = 1'b1;
        @(negedge ref_clk);
        pulse_clear();
        check("R5 clear after zero timeout", status_o, 1'b0);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule